// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block tracks the chip's power mode and turns it into clock enables, a regulator choice and stop requests to peripherals. There are two families of modes, normal and very-low-power, and each family has a run, a wait and a stop mode. The processor's sleep request leads to the wait mode of the current family, and its deep-sleep request leads to the stop mode. A software-written run-mode field moves the chip between normal run and very-low-power run. A wake-up event returns a wait or stop mode to the run mode of the same family.

Stop entry uses a handshake with the peripherals. The core clock and the core's system clock are gated at once, and a stop request goes to every peripheral. The system clock to other bus masters, the bus clocks and the flash clock stay on until every peripheral acknowledges the request. A wake-up that arrives before all acknowledges are in cancels the stop entry, so those clocks are never gated.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it is released, mode_code is 0 (normal run). The core, system, master and flash clock enables are 1, bus_clk_en equals bus_clk_cfg, stop_req is all zeros, reg_stop_sel is 0 and freq_restrict is 0.
- R2: In normal run, a deep-sleep request selects normal stop (code 2). Otherwise a sleep request selects normal wait (code 1). Otherwise a run-mode write with run_mode_vlp=1 selects very-low-power run (code 3). The new mode appears one clock edge after the inputs are sampled.
- R3: In very-low-power run, a deep-sleep request selects very-low-power stop (code 5). Otherwise a sleep request selects very-low-power wait (code 4). Otherwise a run-mode write with run_mode_vlp=0 returns to normal run (code 0).
- R4: In both wait modes, core_clk_en is 0 and sys_clk_en, master_clk_en and flash_clk_en are 1. bus_clk_en equals bus_clk_cfg and stop_req is all zeros.
- R5: In both stop modes, core_clk_en and sys_clk_en are 0 and every stop_req bit is 1, starting in the first cycle of the mode.
- R6: In a stop mode, master_clk_en, flash_clk_en and bus_clk_en keep their run values until a cycle in which every stop_ack bit is 1. From the next cycle they are all 0, and they stay 0 until wake-up.
- R7: A wake-up returns normal wait or stop to code 0, and very-low-power wait or stop to code 3, one edge later. All clock enables are restored and stop_req is cleared in that same cycle.
- R8: A wake-up before all stop acknowledges have been seen cancels the stop entry. The block returns to the run mode it came from, and master, flash and bus clocks are never gated. Wake-up has priority over a full acknowledge in the same cycle.
- R9: reg_stop_sel is 0 in codes 0 to 2 and 1 in codes 3 to 5. freq_restrict is 1 only in codes 3 and 4.
- R10: A run-mode write has no effect except the write with run_mode_vlp=1 in normal run and the write with run_mode_vlp=0 in very-low-power run. Wake-up has no effect in the run modes. Sleep and deep-sleep requests have no effect in wait or stop modes.
- R11: mode_code reports normal run=0, normal wait=1, normal stop=2, very-low-power run=3, very-low-power wait=4, very-low-power stop=5, and never any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Processor sleep request |
| deep_sleep_req | input | 1 | Processor deep-sleep request |
| run_mode_wr | input | 1 | Write strobe of the run-mode field |
| run_mode_vlp | input | 1 | Value written: 1 very-low-power run, 0 normal run |
| wake | input | 1 | Wake-up event |
| stop_ack | input | NUM_PERIPH | Per-peripheral stop acknowledge |
| bus_clk_cfg | input | NUM_BUS | Bus clocks enabled by configuration |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable toward the core |
| master_clk_en | output | 1 | System clock enable toward other masters |
| bus_clk_en | output | NUM_BUS | Bus clock enables |
| flash_clk_en | output | 1 | Flash clock enable |
| stop_req | output | NUM_PERIPH | Per-peripheral stop request |
| reg_stop_sel | output | 1 | Regulator select: 0 run regulation, 1 stop regulation |
| freq_restrict | output | 1 | Frequencies restricted |
| mode_code | output | 3 | Current mode code |

## Verification
The mode register is the only state. A request, write, wake-up or full acknowledge sampled at one clock edge changes mode_code and every output exactly one edge later, because all outputs are decoded from that register without further staging. The bench drives inputs at the falling edge and lets one rising edge pass. At the next falling edge it steps its own model with the inputs it applied and compares every output. A late or early change therefore shows up as a mismatch in that cycle. The directed cases hold acknowledges low over several cycles to show the bus clocks do not move early. They also put wake-up and a full acknowledge in the same cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   localparam int MODE_W = 3;

   // internal sequencing states; handshake states sit between run and stop
   typedef enum logic [2:0] {
      ST_RUN      = 3'd0,
      ST_WAIT     = 3'd1,
      ST_STOP_HS  = 3'd2,
      ST_STOP     = 3'd3,
      ST_VRUN     = 3'd4,
      ST_VWAIT    = 3'd5,
      ST_VSTOP_HS = 3'd6,
      ST_VSTOP    = 3'd7
   } lpm_state_e;

   // reported mode codes
   typedef enum logic [MODE_W-1:0] {
      MC_RUN   = 3'd0,
      MC_WAIT  = 3'd1,
      MC_STOP  = 3'd2,
      MC_VRUN  = 3'd3,
      MC_VWAIT = 3'd4,
      MC_VSTOP = 3'd5
   } lpm_mode_e;

   typedef struct packed {
      logic core;
      logic sys;
      logic master;
      logic periph;
      logic flash;
      logic stop_req;
      logic reg_stop;
      logic freq_lim;
   } lpm_ctl_t;

endpackage

// File: rtl/lpm_next_state.sv
module lpm_next_state
   import lpm_pkg::*;
(
   input  lpm_state_e cur,
   input  logic       sleep_req,
   input  logic       deep_sleep_req,
   input  logic       run_mode_wr,
   input  logic       run_mode_vlp,
   input  logic       wake,
   input  logic       ack_all,
   output lpm_state_e nxt
);

   always_comb begin
      nxt = cur;
      unique case (cur)
         ST_RUN: begin
            if (deep_sleep_req)                  nxt = ST_STOP_HS;
            else if (sleep_req)                  nxt = ST_WAIT;
            else if (run_mode_wr && run_mode_vlp) nxt = ST_VRUN;
         end
         ST_WAIT:    if (wake) nxt = ST_RUN;
         ST_STOP_HS: begin
            if (wake)         nxt = ST_RUN;
            else if (ack_all) nxt = ST_STOP;
         end
         ST_STOP:    if (wake) nxt = ST_RUN;
         ST_VRUN: begin
            if (deep_sleep_req)                   nxt = ST_VSTOP_HS;
            else if (sleep_req)                   nxt = ST_VWAIT;
            else if (run_mode_wr && !run_mode_vlp) nxt = ST_RUN;
         end
         ST_VWAIT:   if (wake) nxt = ST_VRUN;
         ST_VSTOP_HS: begin
            if (wake)         nxt = ST_VRUN;
            else if (ack_all) nxt = ST_VSTOP;
         end
         ST_VSTOP:   if (wake) nxt = ST_VRUN;
         default:    nxt = ST_RUN;
      endcase
   end

endmodule

// File: rtl/lpm_out_decode.sv
module lpm_out_decode
   import lpm_pkg::*;
(
   input  lpm_state_e cur,
   output lpm_ctl_t   ctl,
   output lpm_mode_e  code
);

   always_comb begin
      ctl  = '{core: 1'b1, sys: 1'b1, master: 1'b1, periph: 1'b1,
               flash: 1'b1, stop_req: 1'b0, reg_stop: 1'b0, freq_lim: 1'b0};
      code = MC_RUN;
      unique case (cur)
         ST_RUN: code = MC_RUN;
         ST_WAIT: begin
            ctl.core = 1'b0;
            code     = MC_WAIT;
         end
         ST_STOP_HS: begin
            ctl.core     = 1'b0;
            ctl.sys      = 1'b0;
            ctl.stop_req = 1'b1;
            code         = MC_STOP;
         end
         ST_STOP: begin
            ctl          = '0;
            ctl.stop_req = 1'b1;
            code         = MC_STOP;
         end
         ST_VRUN: begin
            ctl.reg_stop = 1'b1;
            ctl.freq_lim = 1'b1;
            code         = MC_VRUN;
         end
         ST_VWAIT: begin
            ctl.core     = 1'b0;
            ctl.reg_stop = 1'b1;
            ctl.freq_lim = 1'b1;
            code         = MC_VWAIT;
         end
         ST_VSTOP_HS: begin
            ctl.core     = 1'b0;
            ctl.sys      = 1'b0;
            ctl.stop_req = 1'b1;
            ctl.reg_stop = 1'b1;
            code         = MC_VSTOP;
         end
         ST_VSTOP: begin
            ctl          = '0;
            ctl.stop_req = 1'b1;
            ctl.reg_stop = 1'b1;
            code         = MC_VSTOP;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/lpm_ack_reduce.sv
module lpm_ack_reduce #(
   parameter int NUM_PERIPH = 4
) (
   input  logic [NUM_PERIPH-1:0] ack,
   output logic                  all_set
);

   generate
      if (NUM_PERIPH == 1) begin : g_single
         assign all_set = ack[0];
      end else begin : g_tree
         logic [NUM_PERIPH-1:0] chain;
         assign chain[0] = ack[0];
         for (genvar i = 1; i < NUM_PERIPH; i++) begin : g_and
            assign chain[i] = chain[i-1] & ack[i];
         end
         assign all_set = chain[NUM_PERIPH-1];
      end
   endgenerate

endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
   import lpm_pkg::*;
#(
   parameter int NUM_PERIPH = 4,
   parameter int NUM_BUS    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sleep_req,
   input  logic                  deep_sleep_req,
   input  logic                  run_mode_wr,
   input  logic                  run_mode_vlp,
   input  logic                  wake,
   input  logic [NUM_PERIPH-1:0] stop_ack,
   input  logic [NUM_BUS-1:0]    bus_clk_cfg,
   output logic                  core_clk_en,
   output logic                  sys_clk_en,
   output logic                  master_clk_en,
   output logic [NUM_BUS-1:0]    bus_clk_en,
   output logic                  flash_clk_en,
   output logic [NUM_PERIPH-1:0] stop_req,
   output logic                  reg_stop_sel,
   output logic                  freq_restrict,
   output logic [MODE_W-1:0]     mode_code
);

   generate
      if (NUM_PERIPH < 1) begin : g_bad_periph
         $error("NUM_PERIPH must be at least 1");
      end
      if (NUM_BUS < 1) begin : g_bad_bus
         $error("NUM_BUS must be at least 1");
      end
   endgenerate

   lpm_state_e state_q, state_d;
   lpm_ctl_t   ctl;
   lpm_mode_e  code;
   logic       ack_all;

   lpm_ack_reduce #(.NUM_PERIPH(NUM_PERIPH)) u_ack (
      .ack     (stop_ack),
      .all_set (ack_all)
   );

   lpm_next_state u_nxt (
      .cur            (state_q),
      .sleep_req      (sleep_req),
      .deep_sleep_req (deep_sleep_req),
      .run_mode_wr    (run_mode_wr),
      .run_mode_vlp   (run_mode_vlp),
      .wake           (wake),
      .ack_all        (ack_all),
      .nxt            (state_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RUN;
      else        state_q <= state_d;
   end

   lpm_out_decode u_dec (
      .cur  (state_q),
      .ctl  (ctl),
      .code (code)
   );

   assign core_clk_en   = ctl.core;
   assign sys_clk_en    = ctl.sys;
   assign master_clk_en = ctl.master;
   assign flash_clk_en  = ctl.flash;
   assign reg_stop_sel  = ctl.reg_stop;
   assign freq_restrict = ctl.freq_lim;
   assign mode_code     = code;

   generate
      for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
         assign bus_clk_en[b] = ctl.periph & bus_clk_cfg[b];
      end
      for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_req
         assign stop_req[p] = ctl.stop_req;
      end
   endgenerate

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk #(
   parameter int NUM_PERIPH = 4,
   parameter int NUM_BUS    = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sleep_req,
   input logic                  deep_sleep_req,
   input logic                  wake,
   input logic [NUM_PERIPH-1:0] stop_ack,
   input logic                  core_clk_en,
   input logic                  sys_clk_en,
   input logic                  master_clk_en,
   input logic [NUM_BUS-1:0]    bus_clk_en,
   input logic                  flash_clk_en,
   input logic [NUM_PERIPH-1:0] stop_req,
   input logic                  reg_stop_sel,
   input logic                  freq_restrict,
   input logic [2:0]            mode_code
);

   // R6
   master_gate_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(master_clk_en) |-> $past(&stop_ack));

   // R6
   bus_follows_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !master_clk_en |-> (bus_clk_en == '0 && !flash_clk_en));

   // R7
   wake_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd1 && wake) |=> (mode_code == 3'd0 && core_clk_en && stop_req == '0));

   // R3
   vlp_deep_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd3 && deep_sleep_req) |=> mode_code == 3'd5);

   // R2
   run_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd0 && sleep_req && !deep_sleep_req) |=> mode_code == 3'd1);

   // R9
   vlp_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd3 || mode_code == 3'd4) |-> (freq_restrict && reg_stop_sel && flash_clk_en));

   // R5
   stop_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd2 || mode_code == 3'd5) |-> (!core_clk_en && !sys_clk_en && &stop_req));

   // R4
   wait_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_code == 3'd1 || mode_code == 3'd4) |-> (!core_clk_en && sys_clk_en && master_clk_en && stop_req == '0));

   // R11
   mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_code <= 3'd5);

endmodule

bind lpm_seq_ctrl lpm_seq_chk #(.NUM_PERIPH(NUM_PERIPH), .NUM_BUS(NUM_BUS)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sleep_req      (sleep_req),
   .deep_sleep_req (deep_sleep_req),
   .wake           (wake),
   .stop_ack       (stop_ack),
   .core_clk_en    (core_clk_en),
   .sys_clk_en     (sys_clk_en),
   .master_clk_en  (master_clk_en),
   .bus_clk_en     (bus_clk_en),
   .flash_clk_en   (flash_clk_en),
   .stop_req       (stop_req),
   .reg_stop_sel   (reg_stop_sel),
   .freq_restrict  (freq_restrict),
   .mode_code      (mode_code)
);

// File: tb/lpm_seq_ctrl_test.sv
`timescale 1ns/1ps
module lpm_seq_ctrl_test;

   localparam int NP = 4;
   localparam int NB = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_req = 1'b0, deep_sleep_req = 1'b0;
   logic          run_mode_wr = 1'b0, run_mode_vlp = 1'b0, wake = 1'b0;
   logic [NP-1:0] stop_ack = '0;
   logic [NB-1:0] bus_clk_cfg = 3'b101;
   logic          core_clk_en, sys_clk_en, master_clk_en, flash_clk_en;
   logic [NB-1:0] bus_clk_en;
   logic [NP-1:0] stop_req;
   logic          reg_stop_sel, freq_restrict;
   logic [2:0]    mode_code;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // model state: mode code plus "clocks gated" flag inside a stop mode
   int m_mode = 0;
   bit m_gated = 1'b0;

   always #2 clk = ~clk;

   lpm_seq_ctrl #(.NUM_PERIPH(NP), .NUM_BUS(NB)) uut (.*);

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic void model_step();
      case (m_mode)
         0: if (deep_sleep_req) begin m_mode = 2; m_gated = 0; end
            else if (sleep_req) m_mode = 1;
            else if (run_mode_wr && run_mode_vlp) m_mode = 3;
         1: if (wake) m_mode = 0;
         2: if (wake) begin m_mode = 0; m_gated = 0; end
            else if (&stop_ack) m_gated = 1;
         3: if (deep_sleep_req) begin m_mode = 5; m_gated = 0; end
            else if (sleep_req) m_mode = 4;
            else if (run_mode_wr && !run_mode_vlp) m_mode = 0;
         4: if (wake) m_mode = 3;
         5: if (wake) begin m_mode = 3; m_gated = 0; end
            else if (&stop_ack) m_gated = 1;
         default: m_mode = 0;
      endcase
   endfunction

   function automatic bit e_core(); return m_mode == 0 || m_mode == 3; endfunction
   function automatic bit e_sys(); return m_mode != 2 && m_mode != 5; endfunction
   function automatic bit e_stop(); return m_mode == 2 || m_mode == 5; endfunction

   task automatic check_all(input string tag);
      chk(tag, "mode_code R11", 32'(mode_code), 32'(m_mode));
      chk(tag, "core_clk_en R4", 32'(core_clk_en), 32'(e_core()));
      chk(tag, "sys_clk_en R5", 32'(sys_clk_en), 32'(e_sys()));
      chk(tag, "master_clk_en R6", 32'(master_clk_en), 32'(!m_gated));
      chk(tag, "flash_clk_en R6", 32'(flash_clk_en), 32'(!m_gated));
      chk(tag, "bus_clk_en R6", 32'(bus_clk_en), 32'(m_gated ? '0 : bus_clk_cfg));
      chk(tag, "stop_req R5", 32'(stop_req), 32'(e_stop() ? {NP{1'b1}} : '0));
      chk(tag, "reg_stop_sel R9", 32'(reg_stop_sel), 32'(m_mode >= 3));
      chk(tag, "freq_restrict R9", 32'(freq_restrict), 32'(m_mode == 3 || m_mode == 4));
   endtask

   // inputs already applied at a falling edge; pass one rising edge, then compare
   task automatic cyc(input string tag);
      @(posedge clk);
      @(negedge clk);
      model_step();
      check_all(tag);
   endtask

   task automatic idle();
      sleep_req = 0; deep_sleep_req = 0; run_mode_wr = 0; wake = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5a5a));
      // R1 reset values while held and after release
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      cyc("R1");

      // R10 run-mode write of normal value in RUN is ignored; wake ignored
      run_mode_wr = 1; run_mode_vlp = 0; wake = 1;
      cyc("R10");
      idle();
      // R2 deep sleep, acks held low: bus clocks stay on (R5/R6)
      deep_sleep_req = 1; sleep_req = 1;
      cyc("R2");
      idle(); stop_ack = 4'b0111;
      repeat (3) cyc("R6");
      // R8 wake together with full ack: wake wins, nothing gated
      wake = 1; stop_ack = '1;
      cyc("R8");
      idle(); stop_ack = '0;
      // R2 enter VLPR
      run_mode_wr = 1; run_mode_vlp = 1;
      cyc("R2");
      idle();
      // R3 VLPR -> VLPS with full acks, then gate, then wake back to VLPR (R7)
      deep_sleep_req = 1;
      cyc("R3");
      idle(); stop_ack = '1;
      cyc("R6");
      stop_ack = '0; sleep_req = 1; deep_sleep_req = 1;
      cyc("R10");
      idle(); wake = 1;
      cyc("R7");
      idle();
      // R3 VLPW, then VLP write ignored inside wait (R10)
      sleep_req = 1;
      cyc("R3");
      idle(); run_mode_wr = 1; run_mode_vlp = 0;
      cyc("R10");
      idle(); wake = 1;
      cyc("R7");
      idle(); run_mode_wr = 1; run_mode_vlp = 0;
      cyc("R3");
      idle();

      // random phase
      for (int i = 0; i < 4000; i++) begin
         sleep_req      = ($urandom_range(99) < 10);
         deep_sleep_req = ($urandom_range(99) < 6);
         run_mode_wr    = ($urandom_range(99) < 10);
         run_mode_vlp   = $urandom_range(1);
         wake           = ($urandom_range(99) < 9);
         for (int p = 0; p < NP; p++) stop_ack[p] = ($urandom_range(99) < 75);
         if ($urandom_range(99) < 3) bus_clk_cfg = NB'($urandom);
         cyc("R2/R3/R7 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule